// File: doc/BRIEF.md
# Programmable TFT Panel Raster Timing Generator

This block produces the raster timing for a parallel-RGB TFT panel from the single dot clock that also clocks the block. Software programs the active width and height and, on each axis, the front porch, sync pulse width and back porch through a small write port. The block then drives horizontal and vertical sync, a display-enable data qualifier, and the coordinate of the pixel being shown. It passes an 18-bit RGB word (three 6-bit channels) from an external pixel source to the panel pins, and it drives a backlight/panel enable.

Each axis is a segment state machine with four states, visited in a fixed cycle: `SEG_ACTIVE` goes to `SEG_FRONT`, then `SEG_SYNC`, then `SEG_BACK`, and back to `SEG_ACTIVE`. A state is left on the last count of its segment. The horizontal machine steps on every dot clock. The vertical machine steps once per completed line. When the run bit is clear, both machines are forced to `SEG_ACTIVE` with a count of zero. Horizontal porch and sync lengths are programmed in units of 8 dot clocks and vertical ones in whole lines, so line and frame totals are sums of the programmed segments. Timing values are copied into a working set only at a frame boundary, or continuously while stopped.

Top module: `tft_panel_timing`

## Requirements
- R1: After synchronous reset, `panel_de` and `backlight_en` are 0, `pix_x` and `pix_y` are 0, and both sync pins sit at their inactive level, which is 1 with the polarity bits clear.
- R2: Write addresses: 0 is active width, 1 is horizontal front porch, 2 is horizontal sync width, 3 is horizontal back porch, 4 is active height, 5 is vertical front porch, 6 is vertical sync width, 7 is vertical back porch, and 8 is control (bit 0 run, bit 1 hsync invert, bit 2 vsync invert). Writes to addresses 9 to 15 change nothing.
- R3: A line lasts active width + 8 x (front + sync + back) dot clocks, in the order active, front porch, sync, back porch.
- R4: The line counter advances only at the end of a line. A frame lasts active height + front + sync + back lines, in the same segment order.
- R5: `panel_de` is 1 exactly when both axes are in their active segment. `pix_x` and `pix_y` give the offset inside the active segment of each axis and are 0 outside it.
- R6: `panel_hsync` is asserted for the whole horizontal sync segment. It is active low, and becomes active high when control bit 1 is set.
- R7: `panel_vsync` is asserted for every dot clock of the lines in the vertical sync segment. It is active low, and becomes active high when control bit 2 is set.
- R8: `rgb_out` equals `rgb_in` while `panel_de` is 1 and is all zero otherwise.
- R9: Timing values written while running take effect at the first pixel of the next frame. The current frame finishes with the old values.
- R10: A timing value of 0 behaves as 1 (one unit: 8 dot clocks for horizontal porches and sync, one line for vertical ones, one pixel or line for active sizes).
- R11: `backlight_en` follows the run bit. Setting run starts output at pixel (0,0) in the next cycle. Clearing run makes `panel_de` 0 and the syncs inactive in the next cycle, and the next start is again at (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | CW (11) | Configuration write data |
| rgb_in | input | 3*COLOR_W (18) | Pixel word from the pixel source, red in the top bits |
| panel_hsync | output | 1 | Horizontal sync pin, polarity programmable |
| panel_vsync | output | 1 | Vertical sync pin, polarity programmable |
| panel_de | output | 1 | Display enable / pixel data valid |
| pix_x | output | CW (11) | Column of the current active pixel |
| pix_y | output | CW (11) | Row of the current active line |
| rgb_out | output | 3*COLOR_W (18) | Pixel word to the panel, blanked outside display enable |
| backlight_en | output | 1 | Backlight and panel power enable |

## Verification
The bench steps an arithmetic model of the raster beside the design every dot clock. It sweeps small configurations in which each porch, sync and active segment is only a few units long, so that segment boundaries, line wraps and frame wraps happen often. Several corner cases are targeted. One is a counter off by one at a segment end, which would stretch or shorten a line and shift every sync edge that follows. Another is a vertical segment that changes in the middle of a line, which would make vsync or display enable start partway across. A third is a working set reloaded immediately rather than at the frame boundary, which would produce a torn frame with mixed geometry. The bench also covers a zero-valued register read literally, which would yield an empty or wrapping segment, and a restart after stop that does not begin at pixel (0,0).

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;

    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

    localparam int unsigned TIMING_REGS = 8;
    localparam int unsigned CTRL_BITS   = 3;

    localparam int unsigned IDX_H_ACT = 0;
    localparam int unsigned IDX_H_FP  = 1;
    localparam int unsigned IDX_H_SW  = 2;
    localparam int unsigned IDX_H_BP  = 3;
    localparam int unsigned IDX_V_ACT = 4;
    localparam int unsigned IDX_V_FP  = 5;
    localparam int unsigned IDX_V_SW  = 6;
    localparam int unsigned IDX_V_BP  = 7;

    localparam logic [3:0] ADDR_CTRL = 4'd8;

    localparam int unsigned CTRL_RUN  = 0;
    localparam int unsigned CTRL_HINV = 1;
    localparam int unsigned CTRL_VINV = 2;

    // Fixed segment cycle of one axis
    function automatic seg_e seg_after(input seg_e s);
        seg_e n;
        unique case (s)
            SEG_ACTIVE: n = SEG_FRONT;
            SEG_FRONT:  n = SEG_SYNC;
            SEG_SYNC:   n = SEG_BACK;
            SEG_BACK:   n = SEG_ACTIVE;
            default:    n = SEG_ACTIVE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tft_tg_regs.sv
module tft_tg_regs
    import tft_tg_pkg::*;
#(
    parameter int unsigned CW        = 11,
    parameter int unsigned H_ACT_RST = 640,
    parameter int unsigned H_FP_RST  = 2,
    parameter int unsigned H_SW_RST  = 12,
    parameter int unsigned H_BP_RST  = 6,
    parameter int unsigned V_ACT_RST = 480,
    parameter int unsigned V_FP_RST  = 12,
    parameter int unsigned V_SW_RST  = 2,
    parameter int unsigned V_BP_RST  = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [CW-1:0] wdata,
    input  logic          load_shadow,
    output logic [CW-1:0] shd [TIMING_REGS],
    output logic          run,
    output logic          hinv,
    output logic          vinv
);

    logic [CW-1:0]        live_q [TIMING_REGS];
    logic [CW-1:0]        shd_q  [TIMING_REGS];
    logic [CTRL_BITS-1:0] ctrl_q;
    logic                 wr_timing;
    logic                 wr_ctrl;

    function automatic logic [CW-1:0] rst_val(input int unsigned i);
        logic [CW-1:0] v;
        unique case (i)
            IDX_H_ACT: v = CW'(H_ACT_RST);
            IDX_H_FP:  v = CW'(H_FP_RST);
            IDX_H_SW:  v = CW'(H_SW_RST);
            IDX_H_BP:  v = CW'(H_BP_RST);
            IDX_V_ACT: v = CW'(V_ACT_RST);
            IDX_V_FP:  v = CW'(V_FP_RST);
            IDX_V_SW:  v = CW'(V_SW_RST);
            default:   v = CW'(V_BP_RST);
        endcase
        return v;
    endfunction

    // Address decode: lower half of the map holds timing, ADDR_CTRL holds control
    always_comb begin
        wr_timing = we && !addr[3];
        wr_ctrl   = we && (addr == ADDR_CTRL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TIMING_REGS; i++) begin
                live_q[i] <= rst_val(i);
                shd_q[i]  <= rst_val(i);
            end
            ctrl_q <= '0;
        end else begin
            if (wr_timing) begin
                live_q[addr[2:0]] <= wdata;
            end
            if (wr_ctrl) begin
                ctrl_q <= wdata[CTRL_BITS-1:0];
            end
            if (load_shadow) begin
                for (int i = 0; i < TIMING_REGS; i++) begin
                    shd_q[i] <= live_q[i];
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < TIMING_REGS; i++) begin
            shd[i] = shd_q[i];
        end
        run  = ctrl_q[CTRL_RUN];
        hinv = ctrl_q[CTRL_HINV];
        vinv = ctrl_q[CTRL_VINV];
    end

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && addr > ADDR_CTRL) |=> ($stable(ctrl_q) && $stable(live_q[0]) && $stable(live_q[7]))); // R2

    AST_SHADOW_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!load_shadow) |=> ($stable(shd_q[IDX_H_ACT]) && $stable(shd_q[IDX_V_SW]))); // R9

endmodule

// File: rtl/tft_tg_axis.sv
module tft_tg_axis
    import tft_tg_pkg::*;
#(
    parameter int unsigned CW         = 11,
    parameter int unsigned UNIT_SHIFT = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic                     step,
    input  logic [CW-1:0]            len_act,
    input  logic [CW-1:0]            len_fp,
    input  logic [CW-1:0]            len_sw,
    input  logic [CW-1:0]            len_bp,
    output seg_e                     seg,
    output logic [CW+UNIT_SHIFT-1:0] cnt,
    output logic                     period_end
);

    localparam int unsigned SW = CW + UNIT_SHIFT;

    seg_e          seg_q, seg_d;
    logic [SW-1:0] cnt_q, cnt_d;
    logic [SW-1:0] seg_len;
    logic          seg_done;

    // Zero is treated as one unit; porch and sync are scaled by the unit size
    function automatic logic [SW-1:0] unit_len(input logic [CW-1:0] raw, input bit scaled);
        logic [SW-1:0] v;
        v = SW'((raw == '0) ? CW'(1) : raw);
        if (scaled) begin
            v = v << UNIT_SHIFT;
        end
        return v;
    endfunction

    always_comb begin
        unique case (seg_q)
            SEG_ACTIVE: seg_len = unit_len(len_act, 1'b0);
            SEG_FRONT:  seg_len = unit_len(len_fp,  1'b1);
            SEG_SYNC:   seg_len = unit_len(len_sw,  1'b1);
            SEG_BACK:   seg_len = unit_len(len_bp,  1'b1);
            default:    seg_len = unit_len(len_act, 1'b0);
        endcase
        seg_done = (cnt_q == seg_len - SW'(1));
    end

    // Next-state logic
    always_comb begin
        seg_d = seg_q;
        cnt_d = cnt_q;
        if (!run) begin
            seg_d = SEG_ACTIVE;
            cnt_d = '0;
        end else if (step) begin
            if (seg_done) begin
                seg_d = seg_after(seg_q);
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + SW'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SEG_ACTIVE;
            cnt_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        seg        = seg_q;
        cnt        = cnt_q;
        period_end = run && step && seg_done && (seg_q == SEG_BACK);
    end

    AST_SEG_ORDER: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && seg_q != $past(seg_q)) |-> (seg_q == seg_after(seg_e'($past(seg_q))))); // R3

    AST_CNT_IN_SEGMENT: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < seg_len)); // R3

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !step) |=> ($stable(cnt_q) && $stable(seg_q))); // R4

    AST_STOP_RETURNS_HOME: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (seg_q == SEG_ACTIVE && cnt_q == '0)); // R11

endmodule

// File: rtl/tft_panel_timing.sv
module tft_panel_timing
    import tft_tg_pkg::*;
#(
    parameter int unsigned CW           = 11,
    parameter int unsigned COLOR_W      = 6,
    parameter int unsigned H_UNIT_SHIFT = 3,
    parameter int unsigned H_ACT_RST    = 640,
    parameter int unsigned H_FP_RST     = 2,
    parameter int unsigned H_SW_RST     = 12,
    parameter int unsigned H_BP_RST     = 6,
    parameter int unsigned V_ACT_RST    = 480,
    parameter int unsigned V_FP_RST     = 12,
    parameter int unsigned V_SW_RST     = 2,
    parameter int unsigned V_BP_RST     = 31
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [3:0]             cfg_addr,
    input  logic [CW-1:0]          cfg_wdata,
    input  logic [3*COLOR_W-1:0]   rgb_in,
    output logic                   panel_hsync,
    output logic                   panel_vsync,
    output logic                   panel_de,
    output logic [CW-1:0]          pix_x,
    output logic [CW-1:0]          pix_y,
    output logic [3*COLOR_W-1:0]   rgb_out,
    output logic                   backlight_en
);

    localparam int unsigned HCW = CW + H_UNIT_SHIFT;

    logic [CW-1:0]  shd [TIMING_REGS];
    logic           run, hinv, vinv;
    logic           load_shadow;
    seg_e           h_seg, v_seg;
    logic [HCW-1:0] h_cnt;
    logic [CW-1:0]  v_cnt;
    logic           h_end, v_end;
    logic           h_in_act, v_in_act;
    logic           hsync_act, vsync_act;

    tft_tg_regs #(
        .CW(CW),
        .H_ACT_RST(H_ACT_RST), .H_FP_RST(H_FP_RST), .H_SW_RST(H_SW_RST), .H_BP_RST(H_BP_RST),
        .V_ACT_RST(V_ACT_RST), .V_FP_RST(V_FP_RST), .V_SW_RST(V_SW_RST), .V_BP_RST(V_BP_RST)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .load_shadow (load_shadow),
        .shd         (shd),
        .run         (run),
        .hinv        (hinv),
        .vinv        (vinv)
    );

    tft_tg_axis #(.CW(CW), .UNIT_SHIFT(H_UNIT_SHIFT)) u_h_axis (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .step       (1'b1),
        .len_act    (shd[IDX_H_ACT]),
        .len_fp     (shd[IDX_H_FP]),
        .len_sw     (shd[IDX_H_SW]),
        .len_bp     (shd[IDX_H_BP]),
        .seg        (h_seg),
        .cnt        (h_cnt),
        .period_end (h_end)
    );

    tft_tg_axis #(.CW(CW), .UNIT_SHIFT(0)) u_v_axis (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .step       (h_end),
        .len_act    (shd[IDX_V_ACT]),
        .len_fp     (shd[IDX_V_FP]),
        .len_sw     (shd[IDX_V_SW]),
        .len_bp     (shd[IDX_V_BP]),
        .seg        (v_seg),
        .cnt        (v_cnt),
        .period_end (v_end)
    );

    // Working set follows the registers while stopped, else only at frame wrap
    always_comb begin
        load_shadow = !run || v_end;
    end

    // Output decode
    always_comb begin
        h_in_act     = run && (h_seg == SEG_ACTIVE);
        v_in_act     = run && (v_seg == SEG_ACTIVE);
        hsync_act    = run && (h_seg == SEG_SYNC);
        vsync_act    = run && (v_seg == SEG_SYNC);
        panel_de     = h_in_act && v_in_act;
        pix_x        = h_in_act ? CW'(h_cnt) : '0;
        pix_y        = v_in_act ? v_cnt : '0;
        panel_hsync  = hsync_act ^ !hinv;
        panel_vsync  = vsync_act ^ !vinv;
        backlight_en = run;
    end

    for (genvar c = 0; c < 3; c++) begin : g_blank
        assign rgb_out[c*COLOR_W +: COLOR_W] = panel_de ? rgb_in[c*COLOR_W +: COLOR_W] : '0;
    end

    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (rst)
        panel_de |-> (!hsync_act && !vsync_act)); // R5

    AST_LINE_STEP_AT_LINE_END: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && v_cnt != $past(v_cnt)) |-> $past(h_end)); // R4

    AST_FRAME_GEOMETRY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(v_end)) |-> ($stable(shd[IDX_H_ACT]) && $stable(shd[IDX_V_BP]))); // R9

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!run) |-> (!panel_de && pix_x == '0 && pix_y == '0)); // R11

endmodule

// File: tb/test_tft_panel_timing.sv
module test_tft_panel_timing;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [10:0] cfg_wdata = '0;
    logic [17:0] rgb_in = '0;
    logic        panel_hsync, panel_vsync, panel_de, backlight_en;
    logic [10:0] pix_x, pix_y;
    logic [17:0] rgb_out;

    always #2 clk = ~clk;

    tft_panel_timing i_tft_panel_timing (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rgb_in(rgb_in), .panel_hsync(panel_hsync), .panel_vsync(panel_vsync),
        .panel_de(panel_de), .pix_x(pix_x), .pix_y(pix_y), .rgb_out(rgb_out),
        .backlight_en(backlight_en)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    int    cyc = 0;
    string phase = "R1";

    int b_reg [8] = '{640, 2, 12, 6, 480, 12, 2, 31};
    int b_ctrl = 0;
    int ha, hf, hs, hb, va, vf, vs, vb;
    int hp = 0, ln = 0;

    function automatic int atleast1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic latch_frame();
        ha = atleast1(b_reg[0]);
        hf = 8 * atleast1(b_reg[1]);
        hs = 8 * atleast1(b_reg[2]);
        hb = 8 * atleast1(b_reg[3]);
        va = atleast1(b_reg[4]);
        vf = atleast1(b_reg[5]);
        vs = atleast1(b_reg[6]);
        vb = atleast1(b_reg[7]);
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s at cycle %0d: actual %0d expected %0d", req, phase, what, cyc, act, exp);
        end
    endtask

    // Compare every output against the arithmetic model of the current cycle
    task automatic check_outputs();
        bit running, hact, vact, hsyn, vsyn, de;
        running = b_ctrl[0];
        hact = hp < ha;
        vact = ln < va;
        hsyn = (hp >= ha + hf) && (hp < ha + hf + hs);
        vsyn = (ln >= va + vf) && (ln < va + vf + vs);
        de   = running && hact && vact;
        chk("R5", "panel_de", panel_de, de);
        chk("R5", "pix_x", pix_x, (running && hact) ? hp : 0);
        chk("R5", "pix_y", pix_y, (running && vact) ? ln : 0);
        chk("R6", "panel_hsync", panel_hsync, (running && hsyn) ^ !b_ctrl[1]);
        chk("R7", "panel_vsync", panel_vsync, (running && vsyn) ^ !b_ctrl[2]);
        chk("R8", "rgb_out", rgb_out, de ? rgb_in : 0);
        chk("R11", "backlight_en", backlight_en, running);
    endtask

    // One dot clock: drive at the falling edge, check, then model the rising edge
    task automatic step_cycle(input bit w, input int a, input int d);
        int htot, vtot;
        rgb_in    = 18'(cyc * 37 + 5);
        cfg_we    = w;
        cfg_addr  = 4'(a);
        cfg_wdata = 11'(d);
        #1;
        check_outputs();
        @(posedge clk);
        htot = ha + hf + hs + hb;
        vtot = va + vf + vs + vb;
        if (!b_ctrl[0]) begin
            hp = 0; ln = 0; latch_frame();
        end else if (hp == htot - 1) begin
            hp = 0;
            if (ln == vtot - 1) begin
                ln = 0; latch_frame();
            end else begin
                ln++;
            end
        end else begin
            hp++;
        end
        if (w) begin
            if (a < 8) b_reg[a] = d;
            else if (a == 8) b_ctrl = d & 7;
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step_cycle(0, 0, 0);
    endtask

    task automatic program_set(input int a0, input int a1, input int a2, input int a3,
                               input int a4, input int a5, input int a6, input int a7);
        step_cycle(1, 0, a0); step_cycle(1, 1, a1); step_cycle(1, 2, a2); step_cycle(1, 3, a3);
        step_cycle(1, 4, a4); step_cycle(1, 5, a5); step_cycle(1, 6, a6); step_cycle(1, 7, a7);
    endtask

    function automatic int frame_len();
        return (ha + hf + hs + hb) * (va + vf + vs + vb);
    endfunction

    initial begin
        latch_frame();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        phase = "R1";
        idle(3);

        // R3 / R4: basic geometry, two frames
        phase = "R3 R4";
        program_set(5, 1, 1, 1, 3, 1, 2, 1);
        step_cycle(1, 8, 1);
        idle(2 * frame_len() + 10);

        // R2: unmapped addresses leave the raster untouched
        phase = "R2";
        for (int a = 9; a < 16; a++) step_cycle(1, a, 0);
        idle(frame_len());

        // R9: mid-frame reprogram, old frame completes first
        phase = "R9";
        idle(40);
        step_cycle(1, 0, 7);
        step_cycle(1, 6, 1);
        idle(2 * frame_len() + 20);

        // R10: zero-valued porches act as one unit
        phase = "R10";
        step_cycle(1, 8, 0);
        program_set(7, 0, 1, 0, 3, 0, 1, 0);
        step_cycle(1, 8, 1);
        idle(2 * frame_len() + 5);

        // R6 / R7: inverted sync polarity while running
        phase = "R6 R7";
        step_cycle(1, 8, 7);
        idle(frame_len() + 5);
        step_cycle(1, 8, 1);

        // R11: stop mid-frame and restart from pixel (0,0)
        phase = "R11";
        idle(50);
        step_cycle(1, 8, 0);
        idle(5);
        step_cycle(1, 8, 1);
        idle(frame_len() + frame_len() / 2);

        // Sweep of small geometries
        phase = "R3 R4 sweep";
        for (int x = 1; x <= 3; x += 2)
            for (int s = 1; s <= 2; s++)
                for (int y = 1; y <= 2; y++)
                    for (int t = 1; t <= 3; t += 2) begin
                        step_cycle(1, 8, 0);
                        program_set(x, 1, s, 2, y, 2, t, 1);
                        step_cycle(1, 8, 1);
                        idle(frame_len() + 12);
                    end
        step_cycle(1, 8, 0);
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule